// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit

This block is the arithmetic core of a 24-bit fixed-point audio datapath. Each issued operation multiplies two 24-bit operands as fractions. Each operand can be read as two's-complement signed or as unsigned, so signed, unsigned and mixed products are all possible. The result either loads one of two 56-bit accumulators or is added to it. Each accumulator is split into an 8-bit guard field (bits 55:48), a 24-bit high word (bits 47:24) and a 24-bit low word (bits 23:0). A round step is optional. It adds half a unit of the high word and then clears the low word.

The unit has two stages. Stage one registers the product and the control. Stage two reads the destination accumulator, adds, rounds if asked, and writes back. The accumulator is read in stage two, after the previous operation has already written. A new operation can therefore be issued every clock, and an operation can use the result of the one just before it without any stall. A 24-bit read port returns the high word of either accumulator. Each accumulator has a registered overflow flag that shows the guard bits are in use.

Top module: `frac_mac_unit`

## Requirements
- R1: While `rst` is high, both accumulators, both overflow flags and `rd_data` are zero.
- R2: `op_code` 1 (load product) writes the fractional product into the selected accumulator (`acc_sel` 0 = A, 1 = B). The fractional product is the 50-bit product of the two widened operands, sign-extended to 56 bits and then shifted left by one bit.
- R3: `op_code` 2 (accumulate) adds the fractional product to the selected accumulator, modulo 2^56.
- R4: When `sgn_x` (or `sgn_y`) is 1, the operand is widened with its sign bit. When it is 0, the operand is widened with a zero and is therefore read as unsigned.
- R5: An operation sampled at clock edge k first shows on the accumulator outputs after edge k+1. It has no visible effect after edge k alone.
- R6: Operations may be issued on consecutive clocks. Each operation uses the accumulator value left by every operation issued before it, with no stall.
- R7: When `rnd_en` is 1 with `op_code` 1 or 2, the value that would be written is increased by 2^23, and bits 23:0 of the result are then cleared.
- R8: `op_code` 3 rounds the selected accumulator in place in the way R7 describes. `opnd_x`, `opnd_y`, `sgn_x`, `sgn_y` and `rnd_en` are ignored.
- R9: `op_code` 0, or `in_valid` low, changes neither accumulator nor flag.
- R10: An operation never changes the accumulator it does not select.
- R11: Each overflow flag is 1 exactly when bits 55:47 of its accumulator are not all equal. The flag is updated on every write to that accumulator.
- R12: `rd_data` is bits 47:24 of accumulator A when `rd_sel` is 0, and of accumulator B when `rd_sel` is 1. It changes in the same cycle as `rd_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue an operation this cycle |
| op_code | input | 2 | 0 none, 1 load product, 2 accumulate, 3 round in place |
| acc_sel | input | 1 | Destination accumulator: 0 A, 1 B |
| sgn_x | input | 1 | 1: treat opnd_x as signed |
| sgn_y | input | 1 | 1: treat opnd_y as signed |
| rnd_en | input | 1 | Round the result of op 1 or 2 |
| opnd_x | input | 24 | First multiplier operand |
| opnd_y | input | 24 | Second multiplier operand |
| rd_sel | input | 1 | Read port accumulator: 0 A, 1 B |
| acc_a | output | 56 | Accumulator A |
| acc_b | output | 56 | Accumulator B |
| ovf_a | output | 1 | Guard bits in use in A |
| ovf_b | output | 1 | Guard bits in use in B |
| rd_data | output | 24 | High word of the accumulator chosen by rd_sel |

## Verification
The assertions assume that reset is applied before any operation is issued. They also assume that the control inputs (`in_valid`, `op_code`, `acc_sel`, `rnd_en`) never carry unknown values at a clock edge. This matters because the hold and rounding properties are keyed on the registered control. The stimulus meets these assumptions. It drives every input to a defined value on the falling edge, holds reset for several cycles first, and produces its random operations from a bench LFSR whose fields are always fully defined.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;
  localparam int DW_DEF = 24;
  localparam int EW_DEF = 8;

  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_MPY = 2'd1,
    OP_MAC = 2'd2,
    OP_RND = 2'd3
  } mac_op_e;

  typedef struct packed {
    logic    valid;
    mac_op_e op;
    logic    sel;
    logic    rnd;
  } mac_ctl_t;
endpackage

// File: rtl/mac_mult_stage.sv
module mac_mult_stage
  import frac_mac_pkg::*;
#(
  parameter int DW = DW_DEF,
  parameter int EW = EW_DEF
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [1:0]              op_code,
  input  logic                    acc_sel,
  input  logic                    sgn_x,
  input  logic                    sgn_y,
  input  logic                    rnd_en,
  input  logic [DW-1:0]           opnd_x,
  input  logic [DW-1:0]           opnd_y,
  output mac_ctl_t                ctl_q,
  output logic [EW+2*DW-1:0]      prod_q
);
  localparam int AW = EW + 2*DW;
  localparam int PW = 2*DW + 2;

  logic signed [DW:0]   x_w, y_w;
  logic signed [PW-1:0] p_raw;
  logic        [AW-1:0] p_ext;
  logic        [AW-1:0] p_frac;
  mac_op_e              op_in;

  // widen each operand by one bit: sign copy or zero
  always_comb begin
    x_w    = $signed({sgn_x & opnd_x[DW-1], opnd_x});
    y_w    = $signed({sgn_y & opnd_y[DW-1], opnd_y});
    p_raw  = x_w * y_w;
    p_ext  = {{(AW-PW){p_raw[PW-1]}}, p_raw};
    p_frac = p_ext << 1;
    op_in  = mac_op_e'(op_code);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      prod_q <= '0;
    end else begin
      ctl_q.valid <= in_valid && (op_in != OP_NOP);
      ctl_q.op    <= op_in;
      ctl_q.sel   <= acc_sel;
      ctl_q.rnd   <= rnd_en;
      if (in_valid) prod_q <= p_frac;
    end
  end
endmodule

// File: rtl/mac_acc_stage.sv
module mac_acc_stage
  import frac_mac_pkg::*;
#(
  parameter int DW = DW_DEF,
  parameter int EW = EW_DEF
) (
  input  mac_ctl_t               ctl_i,
  input  logic [EW+2*DW-1:0]     prod_i,
  input  logic [EW+2*DW-1:0]     acc_cur,
  output logic                   we,
  output logic [EW+2*DW-1:0]     res
);
  localparam int AW = EW + 2*DW;
  localparam logic [AW-1:0] HALF = AW'(1) << (DW-1);

  logic [AW-1:0] base, addend, sum, rounded;
  logic          do_rnd;

  always_comb begin
    base    = (ctl_i.op == OP_MPY) ? '0 : acc_cur;
    addend  = (ctl_i.op == OP_RND) ? '0 : prod_i;
    sum     = base + addend;
    do_rnd  = ctl_i.rnd || (ctl_i.op == OP_RND);
    rounded = sum + HALF;
    rounded[DW-1:0] = '0;
    res     = do_rnd ? rounded : sum;
    we      = ctl_i.valid;
  end
endmodule

// File: rtl/mac_acc_file.sv
module mac_acc_file #(
  parameter int DW   = 24,
  parameter int EW   = 8,
  parameter int NACC = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              we,
  input  logic [((NACC>1)?$clog2(NACC):1)-1:0] wsel,
  input  logic [EW+2*DW-1:0]                wdata,
  output logic [NACC-1:0][EW+2*DW-1:0]      acc_q,
  output logic [NACC-1:0]                   ovf_q
);
  localparam int AW = EW + 2*DW;
  localparam int SW = (NACC > 1) ? $clog2(NACC) : 1;

  logic [AW-2*DW:0] top_bits;
  logic             ovf_new;

  always_comb begin
    top_bits = wdata[AW-1:2*DW-1];
    ovf_new  = !((&top_bits) || !(|top_bits));
  end

  for (genvar g = 0; g < NACC; g++) begin : g_acc
    always_ff @(posedge clk) begin
      if (rst) begin
        acc_q[g] <= '0;
        ovf_q[g] <= 1'b0;
      end else if (we && (wsel == SW'(g))) begin
        acc_q[g] <= wdata;
        ovf_q[g] <= ovf_new;
      end
    end
  end
endmodule

// File: rtl/frac_mac_unit.sv
module frac_mac_unit
  import frac_mac_pkg::*;
#(
  parameter int DW = DW_DEF,
  parameter int EW = EW_DEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [1:0]           op_code,
  input  logic                 acc_sel,
  input  logic                 sgn_x,
  input  logic                 sgn_y,
  input  logic                 rnd_en,
  input  logic [DW-1:0]        opnd_x,
  input  logic [DW-1:0]        opnd_y,
  input  logic                 rd_sel,
  output logic [EW+2*DW-1:0]   acc_a,
  output logic [EW+2*DW-1:0]   acc_b,
  output logic                 ovf_a,
  output logic                 ovf_b,
  output logic [DW-1:0]        rd_data
);
  localparam int AW   = EW + 2*DW;
  localparam int NACC = 2;

  mac_ctl_t                  s1_ctl;
  logic [AW-1:0]             s1_prod;
  logic [NACC-1:0][AW-1:0]   acc_q;
  logic [NACC-1:0]           ovf_q;
  logic [AW-1:0]             acc_cur, wr_data;
  logic                      wr_en;
  logic                      s1_valid, s1_sel, s1_rnd;
  logic [1:0]                s1_op;

  mac_mult_stage #(.DW(DW), .EW(EW)) u_mult (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
    .acc_sel(acc_sel), .sgn_x(sgn_x), .sgn_y(sgn_y), .rnd_en(rnd_en),
    .opnd_x(opnd_x), .opnd_y(opnd_y), .ctl_q(s1_ctl), .prod_q(s1_prod)
  );

  // late read of the destination: previous write already landed
  assign acc_cur = acc_q[s1_ctl.sel];

  mac_acc_stage #(.DW(DW), .EW(EW)) u_add (
    .ctl_i(s1_ctl), .prod_i(s1_prod), .acc_cur(acc_cur),
    .we(wr_en), .res(wr_data)
  );

  mac_acc_file #(.DW(DW), .EW(EW), .NACC(NACC)) u_file (
    .clk(clk), .rst(rst), .we(wr_en), .wsel(s1_ctl.sel),
    .wdata(wr_data), .acc_q(acc_q), .ovf_q(ovf_q)
  );

  assign s1_valid = s1_ctl.valid;
  assign s1_sel   = s1_ctl.sel;
  assign s1_rnd   = s1_ctl.rnd;
  assign s1_op    = s1_ctl.op;

  assign acc_a   = acc_q[0];
  assign acc_b   = acc_q[1];
  assign ovf_a   = ovf_q[0];
  assign ovf_b   = ovf_q[1];
  assign rd_data = acc_q[rd_sel][2*DW-1:DW];
endmodule

// File: rtl/frac_mac_unit_chk.sv
module frac_mac_unit_chk #(
  parameter int DW = 24,
  parameter int EW = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               s1_valid,
  input logic               s1_sel,
  input logic               s1_rnd,
  input logic [1:0]         s1_op,
  input logic [EW+2*DW-1:0] acc_a,
  input logic [EW+2*DW-1:0] acc_b,
  input logic               ovf_a,
  input logic               ovf_b
);
  localparam int AW = EW + 2*DW;

  // R9 R10: accumulator A holds unless a live op targets it
  a_r10_hold_a: assert property (@(posedge clk) disable iff (rst)
    !(s1_valid && !s1_sel) |=> $stable(acc_a));

  // R9 R10: accumulator B holds unless a live op targets it
  a_r10_hold_b: assert property (@(posedge clk) disable iff (rst)
    !(s1_valid && s1_sel) |=> $stable(acc_b));

  // R7 R8: rounded write leaves a clear low word
  a_r7_round_a: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_sel && (s1_rnd || s1_op == 2'd3)) |=> (acc_a[DW-1:0] == '0));

  a_r8_round_b: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_sel && (s1_rnd || s1_op == 2'd3)) |=> (acc_b[DW-1:0] == '0));

  // R11: flags agree with the guard field of each accumulator
  a_r11_ovf_a: assert property (@(posedge clk) disable iff (rst)
    ovf_a == !((&acc_a[AW-1:2*DW-1]) || !(|acc_a[AW-1:2*DW-1])));

  a_r11_ovf_b: assert property (@(posedge clk) disable iff (rst)
    ovf_b == !((&acc_b[AW-1:2*DW-1]) || !(|acc_b[AW-1:2*DW-1])));
endmodule

bind frac_mac_unit frac_mac_unit_chk #(.DW(DW), .EW(EW)) u_chk (
  .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_sel(s1_sel),
  .s1_rnd(s1_rnd), .s1_op(s1_op), .acc_a(acc_a), .acc_b(acc_b),
  .ovf_a(ovf_a), .ovf_b(ovf_b)
);

// File: tb/frac_mac_unit_test.sv
`timescale 1ns/1ps
module frac_mac_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  op_code = 2'd0;
  logic        acc_sel = 1'b0, sgn_x = 1'b0, sgn_y = 1'b0, rnd_en = 1'b0;
  logic [23:0] opnd_x = '0, opnd_y = '0;
  logic        rd_sel = 1'b0;
  logic [55:0] acc_a, acc_b;
  logic        ovf_a, ovf_b;
  logic [23:0] rd_data;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;
  logic [55:0] mA = '0, mB = '0;

  frac_mac_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
    .acc_sel(acc_sel), .sgn_x(sgn_x), .sgn_y(sgn_y), .rnd_en(rnd_en),
    .opnd_x(opnd_x), .opnd_y(opnd_y), .rd_sel(rd_sel),
    .acc_a(acc_a), .acc_b(acc_b), .ovf_a(ovf_a), .ovf_b(ovf_b),
    .rd_data(rd_data)
  );

  always #4 clk = ~clk;

  function automatic logic [55:0] fprod(logic [23:0] x, logic [23:0] y, logic sx, logic sy);
    logic signed [24:0] a, b;
    logic signed [49:0] p;
    a = $signed({sx & x[23], x});
    b = $signed({sy & y[23], y});
    p = a * b;
    return {{6{p[49]}}, p} << 1;
  endfunction

  function automatic logic [55:0] rnd56(logic [55:0] v);
    logic [55:0] r;
    r = v + 56'h800000;
    r[23:0] = '0;
    return r;
  endfunction

  function automatic logic ovfx(logic [55:0] v);
    return !((v[55:47] == 9'h1FF) || (v[55:47] == 9'h000));
  endfunction

  task automatic model(input logic [1:0] op, input logic sel, input logic sx, input logic sy,
                       input logic rn, input logic [23:0] x, input logic [23:0] y);
    logic [55:0] cur, r;
    cur = sel ? mB : mA;
    case (op)
      2'd1: r = rn ? rnd56(fprod(x, y, sx, sy)) : fprod(x, y, sx, sy);
      2'd2: r = rn ? rnd56(cur + fprod(x, y, sx, sy)) : cur + fprod(x, y, sx, sy);
      2'd3: r = rnd56(cur);
      default: r = cur;
    endcase
    if (sel) mB = r; else mA = r;
  endtask

  // drive at a falling edge and update the model
  task automatic drive(input logic [1:0] op, input logic sel, input logic sx, input logic sy,
                       input logic rn, input logic [23:0] x, input logic [23:0] y);
    in_valid = 1'b1; op_code = op; acc_sel = sel;
    sgn_x = sx; sgn_y = sy; rnd_en = rn; opnd_x = x; opnd_y = y;
    model(op, sel, sx, sy, rn, x, y);
  endtask

  task automatic idle();
    in_valid = 1'b0; op_code = 2'd0;
  endtask

  task automatic chk_state(input string tag, input logic [55:0] ea, input logic [55:0] eb);
    vecs++;
    if (acc_a !== ea || acc_b !== eb || ovf_a !== ovfx(ea) || ovf_b !== ovfx(eb)) begin
      errs++;
      $display("FAIL %s acc_a=%h acc_b=%h ovf=%b%b expected %h %h ovf=%b%b",
               tag, acc_a, acc_b, ovf_a, ovf_b, ea, eb, ovfx(ea), ovfx(eb));
    end
  endtask

  task automatic chk_rd(input string tag, input logic [55:0] ea, input logic [55:0] eb);
    logic keep;
    keep = rd_sel;
    rd_sel = 1'b0; #1;
    vecs++;
    if (rd_data !== ea[47:24]) begin
      errs++; $display("FAIL R12 %s rd A actual=%h expected=%h", tag, rd_data, ea[47:24]);
    end
    rd_sel = 1'b1; #1;
    vecs++;
    if (rd_data !== eb[47:24]) begin
      errs++; $display("FAIL R12 %s rd B actual=%h expected=%h", tag, rd_data, eb[47:24]);
    end
    rd_sel = keep;
  endtask

  task automatic chk(input string tag);
    chk_state(tag, mA, mB);
    chk_rd(tag, mA, mB);
  endtask

  // single op: drive, confirm no effect after one edge, result after two
  task automatic op1(input string tag, input logic [1:0] op, input logic sel, input logic sx,
                     input logic sy, input logic rn, input logic [23:0] x, input logic [23:0] y);
    logic [55:0] oa, ob;
    oa = mA; ob = mB;
    drive(op, sel, sx, sy, rn, x, y);
    @(negedge clk); idle();
    chk_state({"R5 early ", tag}, oa, ob);
    @(negedge clk);
    chk(tag);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset");
  endtask

  task automatic t_mpy();
    op1("R2 half*half", 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 24'h400000, 24'h400000);
    vecs++;
    if (acc_a !== 56'h00_200000_000000) begin
      errs++; $display("FAIL R2 literal actual=%h expected=%h", acc_a, 56'h00_200000_000000);
    end
    op1("R2 neg into B", 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 24'hC00000, 24'h400000);
  endtask

  task automatic t_mac();
    op1("R3 acc A", 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 24'h200000, 24'h400000);
    op1("R3 R10 acc B", 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 24'h123456, 24'h654321);
  endtask

  task automatic t_sign();
    op1("R4 unsigned", 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 24'hFFFFFF, 24'hFFFFFF);
    op1("R4 mixed", 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 24'hFFFFFF, 24'h800000);
    vecs++;
    if (acc_b !== 56'hFF_FFFFFF_000000) begin
      errs++; $display("FAIL R4 mixed literal actual=%h expected=%h", acc_b, 56'hFF_FFFFFF_000000);
    end
    op1("R4 mixed swap", 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 24'h800000, 24'hFFFFFF);
  endtask

  task automatic t_round();
    op1("R7 no round", 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 24'h000001, 24'h400000);
    op1("R7 round up", 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 24'h000001, 24'h400000);
    vecs++;
    if (acc_a !== 56'h00_000001_000000) begin
      errs++; $display("FAIL R7 literal actual=%h expected=%h", acc_a, 56'h00_000001_000000);
    end
    op1("R7 mac round", 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 24'h123457, 24'h3FFFFF);
  endtask

  task automatic t_rndop();
    op1("R8 setup", 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 24'h123457, 24'h7FFFFF);
    op1("R8 round A", 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 24'hABCDEF, 24'h55AA55);
    op1("R8 setup B", 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 24'h000003, 24'h200000);
    op1("R8 round B", 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 24'hFFFFFF, 24'h000001);
  endtask

  task automatic t_nop();
    op1("R9 op zero", 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 24'h7FFFFF, 24'h7FFFFF);
    in_valid = 1'b0; op_code = 2'd2; acc_sel = 1'b1;
    opnd_x = 24'h7FFFFF; opnd_y = 24'h7FFFFF;
    @(negedge clk); @(negedge clk);
    idle();
    chk("R9 valid low");
  endtask

  task automatic t_ovf();
    op1("R11 set", 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 24'h800000, 24'h800000);
    vecs++;
    if (ovf_a !== 1'b1) begin
      errs++; $display("FAIL R11 set actual=%b expected=1", ovf_a);
    end
    op1("R11 clear", 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 24'h800000, 24'h400000);
    vecs++;
    if (ovf_a !== 1'b0) begin
      errs++; $display("FAIL R11 clear actual=%b expected=0", ovf_a);
    end
  endtask

  // R6: back-to-back dependent stream, checked every cycle
  task automatic t_b2b();
    logic [55:0] sa [0:40];
    logic [55:0] sb [0:40];
    logic [31:0] lf;
    int n;
    n = 32;
    lf = 32'hACE1_2357;
    sa[0] = mA; sb[0] = mB;
    for (int i = 0; i < n + 2; i++) begin
      int k;
      k = (i >= 1) ? i - 1 : 0;
      chk_state("R6 stream", sa[k], sb[k]);
      if (i < n) begin
        logic [23:0] x, y;
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        x  = lf[23:0];
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        y  = lf[29:6];
        drive((i < 4) ? 2'd2 : lf[1:0], (i < 4) ? 1'b0 : lf[2], lf[3], lf[4], lf[5], x, y);
        sa[i+1] = mA; sb[i+1] = mB;
      end else begin
        idle();
      end
      @(negedge clk);
    end
    chk("R6 R12 stream end");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_mpy();
    t_mac();
    t_sign();
    t_round();
    t_rndop();
    t_nop();
    t_ovf();
    t_b2b();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule